// File: doc/BRIEF.md
# Chip-Select Kicked Watchdog Timer

This block supervises a host processor by watching the chip-select line it already drives for serial transfers. Every qualified falling edge on that line (a transition to low that then stays low long enough) restarts an internal tick counter. If the counter reaches the selected period before the next qualified edge, the block raises a single-cycle expiry pulse that a separate reset sequencer turns into a held system reset.

The period comes from a 2-bit select field. Three codes pick a long, medium or short period, each counted in timebase ticks and set by parameters. The fourth code switches the watchdog off. While the system runs from its backup battery, the count is frozen and ticks are ignored. Counting resumes from the held value when main power returns. Any change of the select field restarts the count, so a new period takes effect at once.

Top module: `cs_kick_watchdog`

## Requirements
- R1: While reset is asserted, `wdt_expire` is 0 and the count is zero. After release, the first expiry needs a full period of ticks.
- R2: Select code 00 gives P_LONG ticks, 01 gives P_MID and 10 gives P_SHORT. `wdt_expire` is 1 in the cycle after the clock edge that samples the period-th tick since the last restart.
- R3: Select code 11 disables the watchdog. No expiry occurs however many ticks arrive, and the count is held at zero.
- R4: The expiry pulse lasts exactly one cycle. The count then restarts from zero, and the next expiry needs another full period.
- R5: A qualified kick restarts the count from zero. A qualified kick is a high-to-low change of `csn_sync` followed by MIN_LOW consecutive low samples.
- R6: Holding `csn_sync` low (or high) gives at most one kick per low interval. A line held steady therefore still lets the period expire, again and again.
- R7: A low pulse of fewer than MIN_LOW samples is not a kick and leaves the count untouched.
- R8: While `on_batt` is 1, ticks and kicks are ignored, the count is held and no expiry occurs. After `on_batt` returns to 0, counting resumes from the held value.
- R9: Any change of `wd_sel` restarts the count from zero and blocks expiry in that cycle.
- R10: When a kick and the tick that would complete the period fall in the same cycle, the kick wins. No expiry occurs and the count restarts from zero.

The controller has four states:
- OFF: disabled.
- COUNT: counting ticks.
- HOLD: frozen on battery.
- FIRE: the expiry pulse.

The transitions are:
- OFF goes to COUNT when a period is selected.
- COUNT goes to FIRE on the completing tick, to HOLD on battery, and to OFF on code 11.
- FIRE returns to COUNT (or to HOLD or OFF) after one cycle.
- HOLD returns to COUNT when main power is back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csn_sync | input | 1 | Synchronized chip-select, active low; its qualified falling edges kick the watchdog |
| wd_sel | input | 2 | Period select: 00 long, 01 medium, 10 short, 11 disabled |
| on_batt | input | 1 | 1 while running from the backup battery; freezes the count |
| tick | input | 1 | One-cycle timebase strobe |
| wdt_expire | output | 1 | One-cycle expiry pulse to the reset sequencer |

## Verification
A kick and the tick that would complete the period can land in the same clock cycle. Of the two, the restart must win.

The bench advances the count to one tick short of the period. It then holds chip-select low just long enough that the qualified kick reaches the controller in the cycle where the completing tick is driven. It judges the outcome by requiring no pulse in that cycle and then an expiry only after a further full period. A design that let the tick win would pulse at once, and one that dropped the kick would pulse a period early.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_HOLD  = 2'd2,
        WD_FIRE  = 2'd3
    } wd_state_e;

    localparam logic [1:0] SEL_LONG  = 2'b00;
    localparam logic [1:0] SEL_MID   = 2'b01;
    localparam logic [1:0] SEL_SHORT = 2'b10;
    localparam logic [1:0] SEL_OFF   = 2'b11;

endpackage

// File: rtl/wdt_kick_filter.sv
// Qualifies a falling edge of the chip-select line: the line must stay low
// for MIN_LOW consecutive samples; one registered kick per low interval.
module wdt_kick_filter #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csn,
    output logic kick
);
    localparam int RUN_W = $clog2(MIN_LOW + 1);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(MIN_LOW);
    localparam logic [RUN_W-1:0] RUN_ARM = RUN_W'(MIN_LOW - 1);

    logic [RUN_W-1:0] run_q;

    // run_q starts saturated so a line already low at reset gives no kick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN_SAT;
            kick  <= 1'b0;
        end else begin
            kick <= !csn && (run_q == RUN_ARM);
            if (csn) begin
                run_q <= '0;
            end else if (run_q != RUN_SAT) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdt_period_sel.sv
// Decodes the period select and flags any change of it.
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int P_LONG  = 800,
    parameter int P_MID   = 400,
    parameter int P_SHORT = 150,
    parameter int CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    output logic [CNT_W-1:0] last_cnt,
    output logic             sel_chg,
    output logic             disabled
);
    logic [1:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_OFF;
        end else begin
            sel_q <= sel;
        end
    end

    assign sel_chg  = (sel != sel_q);
    assign disabled = (sel == SEL_OFF);

    always_comb begin
        unique case (sel)
            SEL_LONG:  last_cnt = CNT_W'(P_LONG - 1);
            SEL_MID:   last_cnt = CNT_W'(P_MID - 1);
            SEL_SHORT: last_cnt = CNT_W'(P_SHORT - 1);
            default:   last_cnt = '0;
        endcase
    end

endmodule

// File: rtl/wdt_tick_counter.sv
// Tick counter with clear priority over increment.
module wdt_tick_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             at_last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == last_cnt);

endmodule

// File: rtl/cs_kick_watchdog.sv
module cs_kick_watchdog
    import wdt_pkg::*;
#(
    parameter int P_LONG  = 800,
    parameter int P_MID   = 400,
    parameter int P_SHORT = 150,
    parameter int MIN_LOW = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn_sync,
    input  logic [1:0] wd_sel,
    input  logic       on_batt,
    input  logic       tick,
    output logic       wdt_expire
);
    localparam int P_MAX1 = (P_LONG > P_MID) ? P_LONG : P_MID;
    localparam int P_MAX  = (P_MAX1 > P_SHORT) ? P_MAX1 : P_SHORT;
    localparam int CNT_W  = $clog2(P_MAX + 1);

    wd_state_e        state_q, state_d;
    logic             kick;
    logic             sel_chg, disabled, at_last;
    logic             cnt_clr, cnt_inc;
    logic [CNT_W-1:0] last_cnt;

    wdt_kick_filter #(.MIN_LOW(MIN_LOW)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .csn  (csn_sync),
        .kick (kick)
    );

    wdt_period_sel #(
        .P_LONG (P_LONG),
        .P_MID  (P_MID),
        .P_SHORT(P_SHORT),
        .CNT_W  (CNT_W)
    ) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (wd_sel),
        .last_cnt(last_cnt),
        .sel_chg (sel_chg),
        .disabled(disabled)
    );

    wdt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .last_cnt(last_cnt),
        .at_last (at_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter controls; priority: off > battery > restart > tick
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                cnt_clr = 1'b1;
                if (!disabled) begin
                    state_d = on_batt ? WD_HOLD : WD_COUNT;
                end
            end
            WD_COUNT: begin
                if (disabled) begin
                    state_d = WD_OFF;
                    cnt_clr = 1'b1;
                end else if (on_batt) begin
                    state_d = WD_HOLD;
                    cnt_clr = sel_chg;
                end else if (kick || sel_chg) begin
                    cnt_clr = 1'b1;
                end else if (tick) begin
                    if (at_last) begin
                        state_d = WD_FIRE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            WD_HOLD: begin
                cnt_clr = sel_chg;
                if (disabled) begin
                    state_d = WD_OFF;
                    cnt_clr = 1'b1;
                end else if (!on_batt) begin
                    state_d = WD_COUNT;
                end
            end
            WD_FIRE: begin
                cnt_clr = 1'b1;
                if (disabled) begin
                    state_d = WD_OFF;
                end else if (on_batt) begin
                    state_d = WD_HOLD;
                end else begin
                    state_d = WD_COUNT;
                end
            end
            default: begin
                state_d = WD_OFF;
                cnt_clr = 1'b1;
            end
        endcase
    end

    assign wdt_expire = (state_q == WD_FIRE);

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] per_sel,
    input logic       on_battery,
    input logic       kick,
    input logic       wdt_expire
);
    // R1: reset leaves no expiry behind
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !wdt_expire);

    // R3: disabled code never lets a pulse out
    a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sel == 2'b11) |=> !wdt_expire);

    // R4: pulse is a single cycle
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expire |=> !wdt_expire);

    // R8: battery backup blocks expiry
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        on_battery |=> !wdt_expire);

    // R9: select change restarts, no pulse
    a_r9_sel_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sel != $past(per_sel)) |=> !wdt_expire);

    // R10: a kick always beats the completing tick
    a_r10_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !wdt_expire);

endmodule

bind cs_kick_watchdog wdt_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .per_sel   (wd_sel),
    .on_battery(on_batt),
    .kick      (kick),
    .wdt_expire(wdt_expire)
);

// File: tb/cs_kick_watchdog_tb.sv
`timescale 1ns/1ps
module cs_kick_watchdog_tb;

    localparam int TP_LONG  = 12;
    localparam int TP_MID   = 8;
    localparam int TP_SHORT = 5;
    localparam int TMIN_LOW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csn_sync = 1'b1;
    logic [1:0] wd_sel = 2'b00;
    logic       on_batt = 1'b0;
    logic       tick = 1'b0;
    logic       wdt_expire;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cs_kick_watchdog #(
        .P_LONG (TP_LONG),
        .P_MID  (TP_MID),
        .P_SHORT(TP_SHORT),
        .MIN_LOW(TMIN_LOW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .csn_sync  (csn_sync),
        .wd_sel    (wd_sel),
        .on_batt   (on_batt),
        .tick      (tick),
        .wdt_expire(wdt_expire)
    );

    task automatic check(input logic exp, input string req);
        checks++;
        if (wdt_expire !== exp) begin
            errors++;
            $display("FAIL %s: wdt_expire=%0b expected %0b at %0t", req, wdt_expire, exp, $time);
        end
    endtask

    // one clock: inputs set at a falling edge, sampled at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // n ticks; expiry expected only after tick number fire_at (0 = none)
    task automatic tick_n(input int n, input int fire_at, input string req);
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            step();
            check(i == fire_at, req);
        end
        tick = 1'b0;
        if (fire_at != 0) begin
            step();
            check(1'b0, "R4 pulse width");
        end
    endtask

    task automatic kick_pulse(input int lows);
        csn_sync = 1'b0;
        repeat (lows) step();
        csn_sync = 1'b1;
        step();
    endtask

    task automatic t_reset();
        repeat (3) step();
        check(1'b0, "R1 during reset");
        rst_n = 1'b1;
        step();
        check(1'b0, "R1 after release");
        tick_n(TP_LONG, TP_LONG, "R1 R2 long period");
        tick_n(TP_LONG, TP_LONG, "R4 repeat expiry");
    endtask

    task automatic t_codes();
        wd_sel = 2'b01;
        step();
        tick_n(TP_MID, TP_MID, "R2 mid period");
        wd_sel = 2'b10;
        step();
        tick_n(TP_SHORT, TP_SHORT, "R2 short period");
    endtask

    task automatic t_disabled();
        wd_sel = 2'b11;
        step();
        tick_n(30, 0, "R3 disabled");
        wd_sel = 2'b00;
        step();
        tick_n(TP_LONG, TP_LONG, "R3 re-enable from zero");
    endtask

    task automatic t_kick();
        tick_n(10, 0, "R5 pre-kick");
        kick_pulse(TMIN_LOW);
        tick_n(TP_LONG, TP_LONG, "R5 kick restart");
    endtask

    task automatic t_short_low();
        tick_n(6, 0, "R7 pre-glitch");
        kick_pulse(TMIN_LOW - 1);
        tick_n(TP_LONG - 6, TP_LONG - 6, "R7 short low ignored");
    endtask

    task automatic t_held_low();
        csn_sync = 1'b0;
        repeat (TMIN_LOW + 1) step();
        tick_n(TP_LONG, TP_LONG, "R6 held low expires");
        tick_n(TP_LONG, TP_LONG, "R6 held low expires again");
        csn_sync = 1'b1;
        step();
        tick_n(TP_LONG, TP_LONG, "R6 held high expires");
    endtask

    task automatic t_battery();
        tick_n(5, 0, "R8 pre-battery");
        on_batt = 1'b1;
        tick_n(20, 0, "R8 frozen ticks");
        csn_sync = 1'b0;
        repeat (TMIN_LOW + 1) step();
        csn_sync = 1'b1;
        step();
        on_batt = 1'b0;
        step();
        check(1'b0, "R8 resume");
        tick_n(TP_LONG - 5, TP_LONG - 5, "R8 resume from held count");
    endtask

    task automatic t_sel_change();
        tick_n(3, 0, "R9 pre-change");
        wd_sel = 2'b10;
        step();
        check(1'b0, "R9 change cycle");
        tick_n(TP_SHORT, TP_SHORT, "R9 full new period");
        wd_sel = 2'b00;
        step();
    endtask

    task automatic t_collide();
        tick_n(TP_LONG - 1, 0, "R10 pre-collision");
        csn_sync = 1'b0;
        repeat (TMIN_LOW) step();
        tick = 1'b1;
        step();
        check(1'b0, "R10 kick beats final tick");
        tick = 1'b0;
        csn_sync = 1'b1;
        step();
        tick_n(TP_LONG, TP_LONG, "R10 restart after collision");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_codes();
        t_disabled();
        wd_sel = 2'b00;
        step();
        t_kick();
        t_short_low();
        t_held_low();
        t_battery();
        t_sel_change();
        t_collide();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule